// File: doc/BRIEF.md
# CEC Frame Transmit Sequencer

This block sends one frame of up to 16 bytes onto the single-wire CEC bus. Bytes are loaded into a small internal array over a plain write port. A one-cycle start command then carries the byte count and the per-frame options. The block waits until the bus has been idle for the requested signal free time. It then emits an optional start bit, and for every byte it sends the eight data bits, an end-of-message bit and an acknowledge slot. All bit timing counts a 0.1 ms tick, which the block derives from the system clock.

The bus output is open-drain style. `line_pull` high means the block pulls the wire low, and `line_in` is the level read back from the wire. While it sends, the block checks that its released high levels really read high. A mismatch inside the header byte's data bits is reported as lost arbitration. A mismatch anywhere later is reported as a transmit error. On completion the block raises `tx_done`. `ack_ok` is also set when every byte was acknowledged. The status stays until the next accepted start.

Top module: `cec_tx_seq`

## Requirements
- R1: A start with a byte count of 1 to 16 keeps `busy` high until the frame ends. A count of 0 or above 16 never pulls the line. It sets `tx_done` and `tx_err` on the next clock instead.
- R2: Before the first bit, the line must read high for a whole run of idle periods of 24 ticks each. `idle_sel` 2'b00 asks for 7 periods, 2'b01 for 5, and 2'b10 or 2'b11 for 3. Any low reading restarts the run.
- R3: With `auto_start` set, a start bit comes first: 37 ticks low within a 45-tick period. With `auto_start` clear, the first low pulse is the first data bit.
- R4: Each data bit is a 24-tick period. A zero is 15 ticks low and a one is 6 ticks low. Bits go out MSB first, starting with array byte 0.
- R5: After each byte's data bits comes an end-of-message bit. It is a one only after the last byte and only when `auto_eom` is set. In every other case it is a zero.
- R6: In the acknowledge slot the block sends a one and samples the line 10 ticks after the slot starts. With `bcast` clear a low reading counts as acknowledged. With `bcast` set a high reading counts as acknowledged.
- R7: With `nack_abort` set, a byte that is not acknowledged ends the frame after its acknowledge slot. With `nack_abort` clear the frame runs to the last byte. In both cases `ack_ok` stays clear.
- R8: If a data bit of byte 0 sends a one and the line reads low at tick 10, the block releases the line at once and ends the frame with `arb_err`.
- R9: If any other bit that sends a one reads low at tick 10, the frame ends with `tx_err`. This covers later data bits and the end-of-message bit, but not the acknowledge slot.
- R10: An accepted start clears all status. The end of a frame sets `tx_done`. At most one of `ack_ok`, `tx_err` and `arb_err` is set. A start while `busy` is ignored.
- R11: A write with `wr_en` stores `wr_data` at array byte `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Array byte write strobe |
| wr_addr | input | 4 | Array byte index |
| wr_data | input | 8 | Array byte value |
| go | input | 1 | Start command, one cycle |
| go_len | input | 5 | Byte count taken with `go` |
| auto_start | input | 1 | Emit a start bit |
| auto_eom | input | 1 | Mark the last byte with an EOM one |
| nack_abort | input | 1 | End the frame on a missing acknowledge |
| idle_sel | input | 2 | Signal free time choice |
| bcast | input | 1 | Broadcast acknowledge polarity |
| line_in | input | 1 | Wire level read back |
| line_pull | output | 1 | Pull the wire low |
| busy | output | 1 | Frame in progress |
| tx_done | output | 1 | Frame finished |
| ack_ok | output | 1 | Every byte acknowledged |
| tx_err | output | 1 | Bad count or bit error |
| arb_err | output | 1 | Arbitration lost in the header |

## Verification
Several properties are checked on every cycle:
- the line is pulled only while a frame is in progress;
- the status is cleared when a frame begins and set when it ends;
- the three outcome flags are exclusive;
- the pull level changes only on a tick edge;
- arbitration loss is only ever reported inside byte 0.

Other behaviour can only be shown by the bench's scenarios, which decode the pulse widths on the wire. These cover the exact waveforms, the idle wait and its restart, the EOM placement, the acknowledge polarity, and the stop and continue rules after a missing acknowledge.

// File: rtl/cec_tx_seq.sv
module cec_tx_seq #(
  parameter int TICK_DIV  = 5000,
  parameter int MAX_BYTES = 16,
  parameter int CW        = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(MAX_BYTES)-1:0] wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         go,
  input  logic [CW-1:0]                go_len,
  input  logic                         auto_start,
  input  logic                         auto_eom,
  input  logic                         nack_abort,
  input  logic [1:0]                   idle_sel,
  input  logic                         bcast,
  input  logic                         line_in,
  output logic                         line_pull,
  output logic                         busy,
  output logic                         tx_done,
  output logic                         ack_ok,
  output logic                         tx_err,
  output logic                         arb_err
);
  localparam int AW = $clog2(MAX_BYTES);
  localparam int TW = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
  localparam int T_SB_LO  = 37;
  localparam int T_SB     = 45;
  localparam int T_ZERO_LO = 15;
  localparam int T_ONE_LO = 6;
  localparam int T_BIT    = 24;
  localparam int T_SMP    = 10;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} st_t;

  st_t           st;
  logic [TW-1:0] pre;
  logic [1:0]    sync;
  logic [7:0]    mem [MAX_BYTES];
  logic [5:0]    ph;
  logic [7:0]    ft;
  logic [CW-1:0] byte_i, len;
  logic [3:0]    bit_i;
  logic          in_sb, r_som, r_eom, r_stop, r_bc, all_ack, byte_nack;
  logic [1:0]    r_sel;
  logic          cur_one;
  logic [5:0]    lo_len, bit_len;
  logic [7:0]    need;

  wire tick    = (pre == TW'(TICK_DIV - 1));
  wire line_hi = sync[1];
  wire [7:0] cur_byte = mem[byte_i[AW-1:0]];
  wire last    = (byte_i == len - CW'(1));
  wire smp     = tick && (st == S_SEND) && !in_sb && (ph == 6'(T_SMP));
  wire lost    = smp && (bit_i != 4'd9) && cur_one && !line_hi;
  wire got_ack = r_bc ? line_hi : !line_hi;
  wire eob     = tick && (st == S_SEND) && (ph == bit_len - 6'd1);

  assign busy      = (st != S_IDLE);
  assign line_pull = (st == S_SEND) && (ph < lo_len);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + TW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_in};

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_comb begin
    if (in_sb)               cur_one = 1'b0;
    else if (bit_i < 4'd8)   cur_one = cur_byte[3'(4'd7 - bit_i)];
    else if (bit_i == 4'd8)  cur_one = r_eom & last;
    else                     cur_one = 1'b1;
  end

  assign lo_len  = in_sb ? 6'(T_SB_LO) : (cur_one ? 6'(T_ONE_LO) : 6'(T_ZERO_LO));
  assign bit_len = in_sb ? 6'(T_SB) : 6'(T_BIT);

  always_comb
    case (r_sel)
      2'b00:   need = 8'(7 * T_BIT);
      2'b01:   need = 8'(5 * T_BIT);
      default: need = 8'(3 * T_BIT);
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; ft <= '0; byte_i <= '0; bit_i <= '0; len <= '0;
      in_sb <= 1'b0; r_som <= 1'b0; r_eom <= 1'b0; r_stop <= 1'b0; r_bc <= 1'b0;
      r_sel <= 2'b00; all_ack <= 1'b0; byte_nack <= 1'b0;
      tx_done <= 1'b0; ack_ok <= 1'b0; tx_err <= 1'b0; arb_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          tx_done <= 1'b0; ack_ok <= 1'b0; tx_err <= 1'b0; arb_err <= 1'b0;
          len <= go_len; r_som <= auto_start; r_eom <= auto_eom;
          r_stop <= nack_abort; r_bc <= bcast; r_sel <= idle_sel;
          all_ack <= 1'b1; byte_nack <= 1'b0;
          if (go_len == '0 || go_len > CW'(MAX_BYTES)) begin
            tx_done <= 1'b1; tx_err <= 1'b1;
          end else begin
            st <= S_WAIT; ft <= '0;
          end
        end
        S_WAIT: if (tick) begin
          if (!line_hi) ft <= '0;
          else if (ft == need - 8'd1) begin
            st <= S_SEND; ph <= '0; in_sb <= r_som; bit_i <= '0; byte_i <= '0;
          end else ft <= ft + 8'd1;
        end
        S_SEND: begin
          if (lost) begin
            st <= S_IDLE; tx_done <= 1'b1;
            if (byte_i == '0 && bit_i < 4'd8) arb_err <= 1'b1;
            else                              tx_err  <= 1'b1;
          end else if (tick) begin
            if (smp && bit_i == 4'd9 && !got_ack) begin
              all_ack <= 1'b0; byte_nack <= 1'b1;
            end
            if (eob) begin
              ph <= '0;
              if (in_sb) in_sb <= 1'b0;
              else if (bit_i == 4'd9) begin
                if (last || (r_stop && byte_nack)) begin
                  st <= S_IDLE; tx_done <= 1'b1; ack_ok <= all_ack;
                end else begin
                  byte_i <= byte_i + CW'(1); bit_i <= '0; byte_nack <= 1'b0;
                end
              end else bit_i <= bit_i + 4'd1;
            end else ph <= ph + 6'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PULL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) line_pull |-> busy); // R1
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> !busy); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!tx_done && !ack_ok && !tx_err && !arb_err)); // R10
  AST_END_FLAGS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> tx_done); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ack_ok, tx_err, arb_err})); // R10
  AST_PULL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$stable(line_pull) |-> $past(tick)); // R4
  AST_ARB_IN_HEADER: assert property (@(posedge clk) disable iff (!rst_n) $rose(arb_err) |-> ($past(byte_i) == '0)); // R8
endmodule

// File: tb/sim_cec_tx_seq.sv
module sim_cec_tx_seq;
  localparam int T = 2;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wr_en, go, auto_start, auto_eom, nack_abort, bcast, line_in;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] go_len;
  logic [1:0] idle_sel;
  logic line_pull, busy, tx_done, ack_ok, tx_err, arb_err;
  logic pull = 1'b0, ext_low = 1'b0, prev = 1'b0;

  assign line_in = !(line_pull | pull | ext_low);

  cec_tx_seq #(.TICK_DIV(T)) u0 (.*);

  int cyc = 0, total = 0, bad = 0;
  int nf, lo_cnt, pcnt = 0, pedge, offs, t0;
  int lowlen[512];
  int ftimes[512];
  logic [15:0] amask;
  logic [7:0] tx[16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    bit trig;
    trig = 1'b0;
    if (line_pull && !prev) begin
      if (nf < 512) ftimes[nf] = cyc;
      if (nf == pedge) trig = 1'b1;
      else if (nf >= offs && ((nf - offs) % 10) == 9 && amask[(nf - offs) / 10]) trig = 1'b1;
      nf = nf + 1; lo_cnt = 1;
    end else if (line_pull) lo_cnt = lo_cnt + 1;
    else if (prev && nf > 0 && nf <= 512) lowlen[nf-1] = lo_cnt;
    if (trig) pcnt = 15 * T;
    else if (pcnt > 0) pcnt = pcnt - 1;
    pull = (pcnt > 0);
    prev = line_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cls(input int l);
    if (l == 37 * T) return 2;
    if (l == 15 * T) return 0;
    if (l == 6 * T) return 1;
    return 9;
  endfunction

  function automatic int expc(input int k, input int n, input bit som, input bit eom);
    int r;
    if (som) begin
      if (k == 0) return 2;
      r = k - 1;
    end else r = k;
    if (r % 10 < 8) return int'(tx[r/10][7 - (r % 10)]);
    if (r % 10 == 8) return (eom && (r / 10) == n - 1) ? 1 : 0;
    return 1;
  endfunction

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 4'(i); wr_data = tx[i];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic send(input int n, input bit som, input bit eom, input bit son, input logic [1:0] sel,
                      input bit bc, input logic [15:0] m, input int pe, input int ext_at, input int poke_at);
    nf = 0; amask = m; pedge = pe; offs = som ? 1 : 0;
    @(negedge clk);
    go = 1'b1; go_len = 5'(n); auto_start = som; auto_eom = eom; nack_abort = son;
    idle_sel = sel; bcast = bc; t0 = cyc;
    @(negedge clk); go = 1'b0;
    if (ext_at > 0) begin
      repeat (ext_at - 1) @(negedge clk);
      ext_low = 1'b1; repeat (10) @(negedge clk); ext_low = 1'b0;
    end
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      go = 1'b1; go_len = 5'd1; @(negedge clk); go = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic bits_ok(input int n, input bit som, input bit eom, input int cnt, input string req);
    int mism = 0, first = -1;
    for (int k = 0; k < cnt && k < 512; k++)
      if (cls(lowlen[k]) != expc(k, n, som, eom)) begin
        mism++;
        if (first < 0) first = k;
      end
    chk(mism == 0, req, first < 0 ? 0 : cls(lowlen[first]), first < 0 ? 0 : expc(first, n, som, eom));
  endtask

  task automatic t_reset;
    chk(!busy && !line_pull, "R1 reset idle", int'(busy), 0);
    chk(!tx_done && !ack_ok && !tx_err && !arb_err, "R10 reset status", int'(tx_done), 0);
  endtask

  task automatic t_main;
    tx[0] = 8'h4A; tx[1] = 8'hC3; tx[2] = 8'h0F;
    load(3);
    send(3, 1, 1, 1, 2'b01, 0, 16'h0007, -1, 0, 300);
    chk(nf == 31, "R4 R10 bit count, restart while busy ignored", nf, 31);
    bits_ok(3, 1, 1, 31, "R11 R4 R5 R6 bit values");
    chk(ftimes[0] - t0 >= 119 * T + 1 && ftimes[0] - t0 <= 120 * T + 2, "R2 free time 5", ftimes[0] - t0, 120 * T);
    chk(ftimes[1] - ftimes[0] == 45 * T, "R3 start period", ftimes[1] - ftimes[0], 45 * T);
    chk(ftimes[2] - ftimes[1] == 24 * T, "R4 data period", ftimes[2] - ftimes[1], 24 * T);
    chk(tx_done && ack_ok && !tx_err && !arb_err, "R10 acked frame status", int'(ack_ok), 1);
  endtask

  task automatic t_plain;
    tx[0] = 8'h81; tx[1] = 8'h7E;
    load(2);
    send(2, 0, 0, 1, 2'b10, 0, 16'h0003, -1, 0, 0);
    chk(nf == 20, "R3 no start bit count", nf, 20);
    bits_ok(2, 0, 0, 20, "R3 R5 no start bit, EOM zero");
    chk(ftimes[0] - t0 >= 71 * T + 1 && ftimes[0] - t0 <= 72 * T + 2, "R2 free time 3", ftimes[0] - t0, 72 * T);
  endtask

  task automatic t_nack;
    tx[0] = 8'h10; tx[1] = 8'h22; tx[2] = 8'h33;
    load(3);
    send(3, 1, 1, 1, 2'b01, 0, 16'h0005, -1, 0, 0);
    chk(nf == 21, "R7 stop on nack length", nf, 21);
    chk(tx_done && !ack_ok && !tx_err && !arb_err, "R7 stop on nack status", int'(ack_ok), 0);
    send(3, 1, 1, 0, 2'b01, 0, 16'h0005, -1, 0, 0);
    chk(nf == 31, "R7 continue after nack length", nf, 31);
    chk(tx_done && !ack_ok, "R7 continue after nack status", int'(ack_ok), 0);
  endtask

  task automatic t_bcast;
    tx[0] = 8'hF0; tx[1] = 8'h36;
    load(2);
    send(2, 1, 1, 1, 2'b01, 1, 16'h0000, -1, 0, 0);
    chk(nf == 21 && ack_ok, "R6 broadcast accepted", int'(ack_ok), 1);
    send(2, 1, 1, 1, 2'b01, 1, 16'h0001, -1, 0, 0);
    chk(nf == 11 && !ack_ok && tx_done, "R6 broadcast rejected", nf, 11);
  endtask

  task automatic t_arb;
    tx[0] = 8'h4F;
    load(1);
    send(1, 1, 1, 1, 2'b01, 0, 16'h0001, 2, 0, 0);
    chk(nf == 3, "R8 arbitration stops frame", nf, 3);
    chk(tx_done && arb_err && !tx_err && !ack_ok, "R8 arbitration status", int'(arb_err), 1);
  endtask

  task automatic t_biterr;
    tx[0] = 8'h20; tx[1] = 8'hFF;
    load(2);
    send(2, 1, 1, 1, 2'b01, 0, 16'h0003, 11, 0, 0);
    chk(nf == 12, "R9 bit error stops frame", nf, 12);
    chk(tx_done && tx_err && !arb_err && !ack_ok, "R9 bit error status", int'(tx_err), 1);
  endtask

  task automatic t_count;
    send(0, 1, 1, 1, 2'b01, 0, 16'h0000, -1, 0, 0);
    chk(nf == 0 && tx_done && tx_err, "R1 zero count", nf, 0);
    send(17, 1, 1, 1, 2'b01, 0, 16'h0000, -1, 0, 0);
    chk(nf == 0 && tx_done && tx_err, "R1 count above 16", nf, 0);
    for (int i = 0; i < 16; i++) tx[i] = 8'(i * 17 + 3);
    load(16);
    send(16, 1, 1, 1, 2'b10, 0, 16'hFFFF, -1, 0, 0);
    chk(nf == 161 && ack_ok, "R1 sixteen bytes", nf, 161);
    bits_ok(16, 1, 1, 161, "R4 R5 sixteen byte bits");
  endtask

  task automatic t_idle_restart;
    tx[0] = 8'h55;
    load(1);
    send(1, 1, 1, 1, 2'b00, 0, 16'h0001, -1, 100, 0);
    chk(ftimes[0] - t0 >= 110 + 167 * T && ftimes[0] - t0 <= 116 + 168 * T,
        "R2 free time restarts after low", ftimes[0] - t0, 112 + 168 * T);
    chk(ack_ok, "R2 frame after restart", int'(ack_ok), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; go = 1'b0; go_len = '0;
    auto_start = 1'b0; auto_eom = 1'b0; nack_abort = 1'b0; idle_sel = '0; bcast = 1'b0;
    nf = 0; lo_cnt = 0; pedge = -1; offs = 0; amask = '0; t0 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_main;
    t_plain;
    t_nack;
    t_bcast;
    t_arb;
    t_biterr;
    t_count;
    t_idle_restart;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule